// File: doc/BRIEF.md
# Pin Event Capture and Counter Reset Unit

This unit attaches to a free-running 24-bit timer and watches one external event pin. The pin passes through a two-flop synchronizer and, when selected, a stability filter. An edge detector then compares each sampled level with the one before it. When an edge of the chosen polarity arrives and the unit is enabled, one of two actions follows. In capture mode the timer value present in that cycle is stored in a read-only capture register. In reset mode the unit sends a one-cycle reset strobe back to the timer.

Either action sets a sticky event flag. Software clears the flag by writing a one to it. An interrupt line follows the flag whenever the interrupt enable bit is set.

Software uses a small word-addressed register port with three registers. Address 0 holds the control word. Address 1 holds the flag. Address 2 returns the captured value.

Top module: `pec_top`

## Requirements
- R1: Control bits [1:0] select the edge: 0 reacts to a 1-to-0 change of the pin, 1 reacts to a 0-to-1 change, and 2 reacts to either change.
- R2: Edge code 3 (control bits [1:0] = 2'b11) never produces a capture, a reset strobe or a flag.
- R3: When control bit 2 (function enable) is 0, pin changes have no effect: no flag, no strobe, and the capture register keeps its value.
- R4: With control bit 3 = 0 (capture mode), a detected edge loads the counter input into the capture register, which reads at address 2 in bits [23:0]. Register writes to address 2 are ignored.
- R5: With control bit 3 = 1 (reset mode), a detected edge raises `cnt_rst_o` for exactly one cycle and leaves the capture register unchanged.
- R6: Every detected edge sets the flag (address 1, bit 0). Writing 1 to that bit clears the flag, and writing 0 leaves it alone. If an edge and a clearing write occur in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the flag is set and control bit 4 (interrupt enable) is 1.
- R8: With control bit 5 = 1, edges are detected on a filtered level. The filter accepts a new level only after the synchronized pin has differed from the accepted level for 3 consecutive clocks, so shorter pulses are ignored.
- R9: Without filtering, a pin change sampled at clock edge N shows up in the flag, the capture register and the strobe right after edge N+2, and not before.
- R10: After reset the control word, the flag and the capture register read 0, and `irq_o` and `cnt_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External event pin, asynchronous |
| cnt_val_i | input | 24 | Current timer counter value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address, used for both reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| cnt_rst_o | output | 1 | One-cycle counter reset strobe |
| irq_o | output | 1 | Event interrupt |

## Verification
The bench builds the unit with its default parameters: a 24-bit counter, two synchronizer stages and a three-clock filter window. With these values the pin latency is short enough that a directed cycle count can pin down the exact edge where results appear. The same values let a two-clock glitch sit next to a three-clock pulse, so one test can show the filter rejecting the first and accepting the second. With a 24-bit counter, distinct captured values such as 0x123456 and 0xFEDCBA tell each capture apart from the one before it and from a stale register.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  typedef enum logic {
    ACT_CAPTURE = 1'b0,
    ACT_RESET   = 1'b1
  } act_mode_e;

  // bit 5 filter, bit 4 irq enable, bit 3 action, bit 2 enable, bits 1:0 edge
  typedef struct packed {
    logic      dbnc_en;
    logic      irq_en;
    act_mode_e mode;
    logic      func_en;
    edge_sel_e edge_sel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_STS = 2'd1;
  localparam logic [1:0] ADDR_CAP = 2'd2;

  localparam int FLAG_BIT = 0;

  function automatic logic edge_hit(edge_sel_e sel, logic prev_lvl, logic cur_lvl);
    logic rise;
    logic fall;
    rise = !prev_lvl && cur_lvl;
    fall = prev_lvl && !cur_lvl;
    case (sel)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise || fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic filter_done(int unsigned run, int unsigned window);
    filter_done = (run + 1 >= window);
  endfunction

endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pec_debounce.sv
module pec_debounce
  import pec_pkg::*;
#(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int CW = $clog2(STABLE + 1);

  logic [CW-1:0] run_q;
  logic          filt_q;
  logic          differ_w;
  logic          accept_w;

  assign differ_w = (raw_i != filt_q);
  assign accept_w = differ_w && filter_done(int'(run_q), STABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (!differ_w) begin
      run_q <= '0;
    end else if (accept_w) begin
      filt_q <= raw_i;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/pec_edge_det.sv
module pec_edge_det
  import pec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  logic      en_i,
  input  edge_sel_e sel_i,
  output logic      evt_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign evt_o = en_i && edge_hit(sel_i, prev_q, lvl_i);

endmodule

// File: rtl/pec_top.sv
module pec_top
  import pec_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DB_STABLE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cnt_rst_o,
  output logic              irq_o
);

  localparam int CAP_PAD = DATA_W - CNT_W;
  localparam int CTL_PAD = DATA_W - CTL_W;

  ctl_t             ctl_q;
  logic             flag_q;
  logic [CNT_W-1:0] cap_q;
  logic             rst_q;

  // named internal events
  logic      sync_lvl_w;
  logic      filt_lvl_w;
  logic      det_lvl_w;
  logic      evt_w;
  logic      wr_ctl_w;
  logic      clr_flag_w;
  logic      func_en_w;
  logic      dbnc_en_w;
  logic      irq_en_w;
  act_mode_e mode_w;
  edge_sel_e sel_w;
  logic      wdata_unused_w;

  assign func_en_w = ctl_q.func_en;
  assign dbnc_en_w = ctl_q.dbnc_en;
  assign irq_en_w  = ctl_q.irq_en;
  assign mode_w    = ctl_q.mode;
  assign sel_w     = ctl_q.edge_sel;

  assign wdata_unused_w = ^reg_wdata_i[DATA_W-1:CTL_W];

  pec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_pin_i),
    .q_o   (sync_lvl_w)
  );

  pec_debounce #(.STABLE(DB_STABLE)) u_dbnc (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (sync_lvl_w),
    .filt_o (filt_lvl_w)
  );

  assign det_lvl_w = dbnc_en_w ? filt_lvl_w : sync_lvl_w;

  pec_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (det_lvl_w),
    .en_i  (func_en_w),
    .sel_i (sel_w),
    .evt_o (evt_w)
  );

  assign wr_ctl_w   = reg_wr_i && (reg_addr_i == ADDR_CTL);
  assign clr_flag_w = reg_wr_i && (reg_addr_i == ADDR_STS) && reg_wdata_i[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_ctl_w) ctl_q <= ctl_t'(reg_wdata_i[CTL_W-1:0]);
  end

  // set has priority over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (evt_w)      flag_q <= 1'b1;
    else if (clr_flag_w) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (evt_w && (mode_w == ACT_CAPTURE)) cap_q <= cnt_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= evt_w && (mode_w == ACT_RESET);
  end

  assign cnt_rst_o = rst_q;
  assign irq_o     = flag_q && irq_en_w;

  always_comb begin
    case (reg_addr_i)
      ADDR_CTL: reg_rdata_o = {{CTL_PAD{1'b0}}, ctl_q};
      ADDR_STS: reg_rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
      ADDR_CAP: reg_rdata_o = {{CAP_PAD{1'b0}}, cap_q};
      default:  reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pec_top_checker.sv
module pec_top_checker #(
  parameter int CNT_W     = 24,
  parameter int DB_STABLE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt,
  input logic             mode,
  input logic             func_en,
  input logic [1:0]       sel,
  input logic [CNT_W-1:0] cnt_in,
  input logic [CNT_W-1:0] cap,
  input logic             flag,
  input logic             rst_o,
  input logic             clr,
  input logic             sync_lvl,
  input logic             filt_lvl
);

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> !rst_o && !$rose(flag));

  assert_reserved_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> !rst_o && !$rose(flag));

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mode) |=> (cap == $past(cnt_in)) && !rst_o);

  assert_reset_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode) |=> rst_o && $stable(cap));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);

  generate
    if (DB_STABLE == 3) begin : g_win3
      assert_filter_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_lvl) |-> ($past(sync_lvl, 1) == filt_lvl) &&
                               ($past(sync_lvl, 2) == filt_lvl) &&
                               ($past(sync_lvl, 3) == filt_lvl));
    end
  endgenerate

endmodule

bind pec_top pec_top_checker #(.CNT_W(CNT_W), .DB_STABLE(DB_STABLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (evt_w),
  .mode     (mode_w),
  .func_en  (func_en_w),
  .sel      (sel_w),
  .cnt_in   (cnt_val_i),
  .cap      (cap_q),
  .flag     (flag_q),
  .rst_o    (rst_q),
  .clr      (clr_flag_w),
  .sync_lvl (sync_lvl_w),
  .filt_lvl (filt_lvl_w)
);

// File: tb/pec_top_bench.sv
module pec_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [23:0] cnt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cnt_rst;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R10";
  logic [23:0] exp_cap = '0;
  bit pin_lvl = 1'b0;

  typedef struct {
    bit          is_rst;
    logic [23:0] cap;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  logic irq_d = 1'b0;
  logic rst_d = 1'b0;

  always #2 clk = ~clk;

  pec_top u_pec_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_pin_i   (pin),
    .cnt_val_i   (cnt),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .cnt_rst_o   (cnt_rst),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops an expected item whenever a result shows up
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((irq && !irq_d) || cnt_rst) begin
        if (sb.size() == 0) begin
          chk(1'b0, cur_req, "unexpected event", {30'b0, cnt_rst, irq}, 32'h0);
        end else begin
          mon_e = sb.pop_front();
          chk(cnt_rst == mon_e.is_rst, mon_e.is_rst ? "R5" : "R4", "strobe kind",
              {31'b0, cnt_rst}, {31'b0, mon_e.is_rst});
          if (addr == 2'd2)
            chk(rdata[23:0] == mon_e.cap, mon_e.is_rst ? "R5" : "R4", "capture value",
                rdata, {8'b0, mon_e.cap});
        end
      end
      if (cnt_rst && rst_d) chk(1'b0, "R5", "strobe longer than one cycle", 32'h2, 32'h1);
      irq_d <= irq;
      rst_d <= cnt_rst;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
    addr = 2'd2;
  endtask

  task automatic cfg(input logic [1:0] sel, input bit fen, input bit md,
                     input bit ien, input bit den);
    wr_reg(2'd0, {26'b0, den, ien, md, fen, sel});
  endtask

  function automatic bit exp_hit(input logic [1:0] sel, input bit from, input bit to);
    if (from == to) return 1'b0;
    case (sel)
      2'd0: return from;
      2'd1: return to;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic move_pin(input bit lvl, input logic [23:0] cv, input logic [1:0] sel,
                          input bit fen, input bit md, input string req);
    bit hit;
    hit = fen && exp_hit(sel, pin_lvl, lvl);
    @(negedge clk);
    cur_req = req;
    cnt = cv;
    if (hit) begin
      if (!md) exp_cap = cv;
      sb.push_back('{md, exp_cap});
    end
    pin = lvl;
    pin_lvl = lvl;
    idle(12);
    chk(sb.size() == 0, req, "scoreboard drained", sb.size(), 32'h0);
    wr_reg(2'd1, 32'h1);
    idle(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rst_n = 1'b1;

    // R10 reset state
    rd_reg(2'd0, v); chk(v == 0, "R10", "control after reset", v, 0);
    rd_reg(2'd1, v); chk(v == 0, "R10", "flag after reset", v, 0);
    rd_reg(2'd2, v); chk(v == 0, "R10", "capture after reset", v, 0);
    chk(irq == 0 && cnt_rst == 0, "R10", "outputs after reset", {30'b0, irq, cnt_rst}, 0);

    // R1 rising
    cfg(2'd1, 1, 0, 1, 0);
    rd_reg(2'd0, v); chk(v == 32'h15, "R1", "control readback", v, 32'h15);
    move_pin(1, 24'h123456, 2'd1, 1, 0, "R1");
    move_pin(0, 24'h111111, 2'd1, 1, 0, "R1");
    // R1 falling
    cfg(2'd0, 1, 0, 1, 0);
    move_pin(1, 24'h222222, 2'd0, 1, 0, "R1");
    move_pin(0, 24'h00ABCD, 2'd0, 1, 0, "R1");
    // R1 both
    cfg(2'd2, 1, 0, 1, 0);
    move_pin(1, 24'hFEDCBA, 2'd2, 1, 0, "R1");
    move_pin(0, 24'h654321, 2'd2, 1, 0, "R1");
    // R2 reserved code
    cfg(2'd3, 1, 0, 1, 0);
    move_pin(1, 24'h0F0F0F, 2'd3, 1, 0, "R2");
    move_pin(0, 24'h0E0E0E, 2'd3, 1, 0, "R2");
    rd_reg(2'd2, v); chk(v[23:0] == exp_cap, "R2", "capture untouched", v, {8'b0, exp_cap});
    // R3 disabled
    cfg(2'd2, 0, 0, 1, 0);
    move_pin(1, 24'h0A0A0A, 2'd2, 0, 0, "R3");
    move_pin(0, 24'h0B0B0B, 2'd2, 0, 0, "R3");
    rd_reg(2'd2, v); chk(v[23:0] == exp_cap, "R3", "capture untouched", v, {8'b0, exp_cap});
    rd_reg(2'd1, v); chk(v == 0, "R3", "flag untouched", v, 0);
    // R5 reset mode
    cfg(2'd2, 1, 1, 1, 0);
    move_pin(1, 24'h777777, 2'd2, 1, 1, "R5");
    move_pin(0, 24'h888888, 2'd2, 1, 1, "R5");
    rd_reg(2'd2, v); chk(v[23:0] == exp_cap, "R5", "capture kept in reset mode", v, {8'b0, exp_cap});
    // R4 capture register read-only
    wr_reg(2'd2, 32'hFFABCDEF);
    rd_reg(2'd2, v); chk(v[23:0] == exp_cap, "R4", "write to capture ignored", v, {8'b0, exp_cap});

    // R9 latency, rising capture, no filter
    cfg(2'd1, 1, 0, 1, 0);
    @(negedge clk);
    cur_req = "R9"; cnt = 24'h0FEDCB; exp_cap = 24'h0FEDCB;
    sb.push_back('{1'b0, exp_cap});
    pin = 1'b1; pin_lvl = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(irq == 0, "R9", "flag before edge N+2", {31'b0, irq}, 0);
    @(negedge clk);
    chk(irq == 1, "R9", "flag after edge N+2", {31'b0, irq}, 1);
    idle(3);
    chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);

    // R6 write 0 no effect, write 1 clears
    rd_reg(2'd1, v); chk(v == 1, "R6", "flag set by edge", v, 1);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd1, v); chk(v == 1, "R6", "write 0 keeps flag", v, 1);
    wr_reg(2'd1, 32'h1);
    rd_reg(2'd1, v); chk(v == 0, "R6", "write 1 clears flag", v, 0);
    // R6 set wins over clear
    move_pin(0, 24'h000100, 2'd1, 1, 0, "R6");
    @(negedge clk);
    cur_req = "R6"; cnt = 24'h0C0C0C; exp_cap = 24'h0C0C0C;
    sb.push_back('{1'b0, exp_cap});
    pin = 1'b1; pin_lvl = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = 2'd1; wdata = 32'h1; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2;
    rd_reg(2'd1, v); chk(v == 1, "R6", "set wins over clear", v, 1);
    idle(3);
    chk(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
    wr_reg(2'd1, 32'h1);

    // R7 interrupt gating
    cfg(2'd1, 1, 0, 0, 0);
    move_pin(0, 24'h000200, 2'd1, 1, 0, "R7");
    @(negedge clk);
    cur_req = "R7"; cnt = 24'h3C3C3C; exp_cap = 24'h3C3C3C;
    pin = 1'b1; pin_lvl = 1'b1;
    idle(8);
    chk(irq == 0, "R7", "irq masked", {31'b0, irq}, 0);
    rd_reg(2'd1, v); chk(v == 1, "R7", "flag set while masked", v, 1);
    sb.push_back('{1'b0, exp_cap});
    cfg(2'd1, 1, 0, 1, 0);
    @(negedge clk);
    chk(irq == 1, "R7", "irq after enable", {31'b0, irq}, 1);
    chk(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
    wr_reg(2'd1, 32'h1);
    @(negedge clk);
    chk(irq == 0, "R7", "irq after clear", {31'b0, irq}, 0);

    // R8 filter
    cfg(2'd1, 1, 0, 1, 1);
    move_pin(0, 24'h000300, 2'd1, 1, 0, "R8");
    @(negedge clk);
    cur_req = "R8"; cnt = 24'h5A5A5A;
    pin = 1'b1;
    idle(2);
    pin = 1'b0;
    idle(12);
    chk(sb.size() == 0 && irq == 0, "R8", "two-cycle glitch ignored", {31'b0, irq}, 0);
    exp_cap = 24'h5A5A5A;
    sb.push_back('{1'b0, exp_cap});
    pin = 1'b1;
    idle(3);
    pin = 1'b0;
    idle(14);
    chk(sb.size() == 0, "R8", "three-cycle pulse accepted", sb.size(), 0);
    rd_reg(2'd2, v); chk(v[23:0] == 24'h5A5A5A, "R8", "filtered capture", v, 32'h5A5A5A);
    wr_reg(2'd1, 32'h1);
    idle(4);

    chk(sb.size() == 0, "R4", "final scoreboard empty", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule